// File: doc/BRIEF.md
# Texture Address Wrap Unit

This unit turns one interpolated texture coordinate pair into the address of a single texel in an on-chip square texture and returns that texel, with no filtering. Each coordinate is a 32-bit signed fixed-point value. Bit 31 is the sign, bit 30 is the single integer bit, and bits 29:0 hold the fraction. Each axis has its own wrap mode, carried with the fragment. Repeat mode drops the sign and integer bit and uses only the fraction. Clamp-to-edge mode pins anything below zero to the first texel, and anything at or above one to the last texel.

Fragments enter on a valid/ready stream. An accepted fragment yields its texel one cycle later on a valid/ready output. While the output holds a texel that has not been taken, `frag_ready` stays low, so back-pressure reaches the producer with no extra buffering. Texture side length comes from a size register that is loaded through `cfg_we`. A host fills the texture through an upload port while `load_active` is high. Texels are written row by row from address zero. Because the single-port texel RAM is busy with the upload, fragment lookups stall for that whole time.

With `MAX_LOG` = 6 the memory holds 64x64 texels and the selectable sides are 64, 32 and 16. Setting `MAX_LOG` = 7 gives a 16 k-texel (32 kB) store with sides 128, 64 and 32.

Top module: `tex_wrap_unit`

## Requirements
- R1: After reset, `texel_valid` is 0 and `frag_ready` is 1 (with `load_active` low).
- R2: In repeat mode (mode bit 0) the sign and integer bits are ignored. The axis index is the top log2(side) bits of the fraction (bits 29 downward), so negative values wrap (-0.25 selects the same texel as 0.75).
- R3: In clamp mode (mode bit 1), a coordinate with bit 31 set selects index 0.
- R4: In clamp mode, a non-negative coordinate with bit 30 set (value >= 1.0) selects index side-1.
- R5: In clamp mode, a coordinate in [0,1) selects the same index as repeat mode.
- R6: The s and t axes apply their own mode bits independently.
- R7: The texel address is t_index*side + s_index. `cfg_size` codes are 0 = 2^MAX_LOG, 1 = half of that, 2 and 3 = a quarter. A code written with `cfg_we` applies to every fragment accepted in later cycles.
- R8: While `load_active` is high, each cycle with `load_valid` writes `load_data` to the next address, starting at 0 each time `load_active` rises. `load_ready` equals `load_active`. Addresses not written keep their old contents.
- R9: While `load_active` is high, `frag_ready` is 0 and no fragment is accepted.
- R10: A fragment accepted at a clock edge produces `texel_valid` = 1 and its texel after that same edge. While `texel_ready` is 0, `texel_valid` and `texel_data` hold, and `frag_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the side-length register |
| cfg_size | input | 2 | Side-length code (0 full, 1 half, 2/3 quarter) |
| frag_valid | input | 1 | Fragment present |
| frag_ready | output | 1 | Fragment accepted this cycle when high with valid |
| frag_s | input | 32 | s coordinate, signed 1-integer-bit fixed point |
| frag_t | input | 32 | t coordinate, same format |
| frag_clamp_s | input | 1 | s mode: 0 repeat, 1 clamp-to-edge |
| frag_clamp_t | input | 1 | t mode: 0 repeat, 1 clamp-to-edge |
| texel_valid | output | 1 | Texel output present |
| texel_ready | input | 1 | Consumer takes the texel |
| texel_data | output | 16 | RGBA4444 texel |
| load_active | input | 1 | Upload window; restarts address at 0 on rise |
| load_valid | input | 1 | Upload texel present |
| load_ready | output | 1 | Upload accepted (equals load_active) |
| load_data | input | 16 | Upload texel |

## Verification
Several rules are checked on every cycle: the output handshake (a held texel stays valid and stable under back-pressure, and blocks new input), the upload stall, the one-cycle latency from acceptance, and the clamp of negative s coordinates to index 0. The address arithmetic needs the bench's scenarios to show it. That covers both wrap modes on each axis, every size code, a size change between fragments, and re-upload over part of the texture. Only the texel values returned from a known uploaded pattern reveal those results.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic {WRAP_REPEAT = 1'b0, WRAP_CLAMP = 1'b1} wrap_e;

  // Right-shift applied to a full-size index for a given size code.
  function automatic logic [1:0] size_shift(input logic [1:0] code);
    case (code)
      2'd0:    size_shift = 2'd0;
      2'd1:    size_shift = 2'd1;
      default: size_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/tw_axis_map.sv
module tw_axis_map
  import tw_pkg::*;
#(
  parameter int CW      = 32,
  parameter int MAX_LOG = 6
) (
  input  logic [CW-1:0]      coord,
  input  wrap_e              mode,
  input  logic [1:0]         shift,
  output logic [MAX_LOG-1:0] idx
);
  localparam int FRAC_TOP = CW - 3;

  logic               sign_b;
  logic               int_b;
  logic [MAX_LOG-1:0] raw;
  logic [MAX_LOG-1:0] scaled;
  logic [MAX_LOG-1:0] last;

  assign sign_b = coord[CW-1];
  assign int_b  = coord[CW-2];
  assign raw    = coord[FRAC_TOP -: MAX_LOG];
  assign scaled = raw >> shift;
  assign last   = {MAX_LOG{1'b1}} >> shift;

  always_comb begin
    idx = scaled;
    if (mode == WRAP_CLAMP) begin
      if (sign_b)     idx = '0;
      else if (int_b) idx = last;
    end
  end
endmodule

// File: rtl/tw_texram.sv
module tw_texram #(
  parameter int TW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [TW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/tex_wrap_unit.sv
module tex_wrap_unit
  import tw_pkg::*;
#(
  parameter int CW      = 32,
  parameter int TW      = 16,
  parameter int MAX_LOG = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_size,
  input  logic          frag_valid,
  output logic          frag_ready,
  input  logic [CW-1:0] frag_s,
  input  logic [CW-1:0] frag_t,
  input  logic          frag_clamp_s,
  input  logic          frag_clamp_t,
  output logic          texel_valid,
  input  logic          texel_ready,
  output logic [TW-1:0] texel_data,
  input  logic          load_active,
  input  logic          load_valid,
  output logic          load_ready,
  input  logic [TW-1:0] load_data
);
  localparam int AW = 2 * MAX_LOG;

  logic [1:0]                   size_q;
  logic [1:0]                   shift;
  logic [1:0][CW-1:0]           coords;
  logic [1:0]                   modes;
  logic [1:0][MAX_LOG-1:0]      axis_idx;
  logic [MAX_LOG-1:0]           s_idx_w;
  logic [AW-1:0]                look_addr;
  logic [AW-1:0]                wr_ptr;
  logic [AW-1:0]                ram_addr;
  logic                         accept;
  logic                         wr_en;
  logic                         out_v_q;

  assign coords = {frag_t, frag_s};
  assign modes  = {frag_clamp_t, frag_clamp_s};
  assign shift  = size_shift(size_q);

  for (genvar a = 0; a < 2; a++) begin : g_axis
    tw_axis_map #(.CW(CW), .MAX_LOG(MAX_LOG)) u_map (
      .coord (coords[a]),
      .mode  (wrap_e'(modes[a])),
      .shift (shift),
      .idx   (axis_idx[a])
    );
  end

  assign s_idx_w   = axis_idx[0];
  assign look_addr = (AW'(axis_idx[1]) << (MAX_LOG - int'(shift))) | AW'(axis_idx[0]);

  assign frag_ready = !load_active && (!out_v_q || texel_ready);
  assign accept     = frag_valid && frag_ready;
  assign load_ready = load_active;
  assign wr_en      = load_active && load_valid;
  assign ram_addr   = load_active ? wr_ptr : look_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q  <= 2'd0;
      wr_ptr  <= '0;
      out_v_q <= 1'b0;
    end else begin
      if (cfg_we) size_q <= cfg_size;
      if (!load_active)  wr_ptr <= '0;
      else if (load_valid) wr_ptr <= wr_ptr + 1'b1;
      if (accept)           out_v_q <= 1'b1;
      else if (texel_ready) out_v_q <= 1'b0;
    end
  end

  tw_texram #(.TW(TW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .re    (accept),
    .addr  (ram_addr),
    .wdata (load_data),
    .rdata (texel_data)
  );

  assign texel_valid = out_v_q;
endmodule

// File: rtl/tex_wrap_unit_chk.sv
module tex_wrap_unit_chk #(
  parameter int CW      = 32,
  parameter int TW      = 16,
  parameter int MAX_LOG = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frag_valid,
  input logic               frag_ready,
  input logic [CW-1:0]      frag_s,
  input logic               frag_clamp_s,
  input logic               load_active,
  input logic               texel_valid,
  input logic               texel_ready,
  input logic [TW-1:0]      texel_data,
  input logic [MAX_LOG-1:0] s_idx
);
  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    texel_valid && !texel_ready |=> texel_valid && $stable(texel_data));

  // R10
  block_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    texel_valid && !texel_ready |-> !frag_ready);

  // R10
  one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid && frag_ready |=> texel_valid);

  // R9
  upload_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_active |-> !frag_ready);

  // R3
  clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frag_valid && frag_ready && frag_clamp_s && frag_s[CW-1] |-> s_idx == '0);
endmodule

bind tex_wrap_unit tex_wrap_unit_chk #(.CW(CW), .TW(TW), .MAX_LOG(MAX_LOG)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frag_valid   (frag_valid),
  .frag_ready   (frag_ready),
  .frag_s       (frag_s),
  .frag_clamp_s (frag_clamp_s),
  .load_active  (load_active),
  .texel_valid  (texel_valid),
  .texel_ready  (texel_ready),
  .texel_data   (texel_data),
  .s_idx        (s_idx_w)
);

// File: tb/tb_tex_wrap_unit.sv
module tb_tex_wrap_unit;
  localparam int CW = 32;
  localparam int TW = 16;
  localparam int MAX_LOG = 6;
  localparam int DEPTH = 1 << (2 * MAX_LOG);
  localparam int NVEC = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_size = 2'd0;
  logic          frag_valid = 1'b0;
  logic          frag_ready;
  logic [CW-1:0] frag_s = '0;
  logic [CW-1:0] frag_t = '0;
  logic          frag_clamp_s = 1'b0;
  logic          frag_clamp_t = 1'b0;
  logic          texel_valid;
  logic          texel_ready = 1'b1;
  logic [TW-1:0] texel_data;
  logic          load_active = 1'b0;
  logic          load_valid = 1'b0;
  logic          load_ready;
  logic [TW-1:0] load_data = '0;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  tex_wrap_unit #(.CW(CW), .TW(TW), .MAX_LOG(MAX_LOG)) dut (.*);

  // {s, t, clamp_s, clamp_t, size code, expected address}
  localparam logic [79:0] VEC [NVEC] = '{
    {32'h2000_0000, 32'h1000_0000, 1'b0, 1'b0, 2'd0, 12'd1056}, // R2
    {32'h6000_0000, 32'h3000_0000, 1'b0, 1'b0, 2'd0, 12'd3104}, // R2 integer bit dropped
    {32'hF000_0000, 32'h2000_0000, 1'b0, 1'b0, 2'd0, 12'd2096}, // R2 negative wraps
    {32'hF000_0000, 32'h2000_0000, 1'b1, 1'b1, 2'd0, 12'd2048}, // R3
    {32'h6000_0000, 32'h1000_0000, 1'b1, 1'b1, 2'd0, 12'd1087}, // R4
    {32'h4000_0000, 32'hC000_0000, 1'b1, 1'b1, 2'd0, 12'd63},   // R3 R4
    {32'h3000_0000, 32'h1000_0000, 1'b1, 1'b1, 2'd0, 12'd1072}, // R5
    {32'h6000_0000, 32'h6000_0000, 1'b0, 1'b1, 2'd0, 12'd4064}, // R6
    {32'h3FFF_FFFF, 32'h3FFF_FFFF, 1'b0, 1'b0, 2'd0, 12'd4095}, // R2 top edge
    {32'h2000_0000, 32'h1000_0000, 1'b0, 1'b0, 2'd1, 12'd272},  // R7 half
    {32'h5000_0000, 32'hF000_0000, 1'b1, 1'b0, 2'd1, 12'd799},  // R6 R7
    {32'h3000_0000, 32'h2000_0000, 1'b0, 1'b0, 2'd2, 12'd140},  // R7 quarter
    {32'hE000_0000, 32'h4000_0000, 1'b1, 1'b1, 2'd2, 12'd240},  // R7 R3 R4
    {32'h2000_0000, 32'h2000_0000, 1'b0, 1'b0, 2'd3, 12'd136}   // R7 code 3
  };

  function automatic logic [TW-1:0] pat(input int a);
    pat = TW'((a * 37) ^ 16'h5A5A);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_size(input logic [1:0] code);
    @(negedge clk);
    cfg_we = 1'b1; cfg_size = code;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Present one fragment at a negedge; after acceptance return at the following negedge.
  task automatic lookup(input logic [CW-1:0] s, input logic [CW-1:0] t,
                        input logic cs, input logic ct);
    @(negedge clk);
    frag_s = s; frag_t = t; frag_clamp_s = cs; frag_clamp_t = ct; frag_valid = 1'b1;
    while (!frag_ready) @(negedge clk);
    @(negedge clk);
    frag_valid = 1'b0;
  endtask

  task automatic upload(input int n, input logic [TW-1:0] base, input bit use_pat);
    @(negedge clk);
    load_active = 1'b1;
    for (int k = 0; k < n; k++) begin
      load_valid = 1'b1;
      load_data = use_pat ? pat(k) : TW'(base + TW'(k));
      @(negedge clk);
    end
    load_valid = 1'b0;
    load_active = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        n_run++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(texel_valid == 1'b0, "R1 valid", int'(texel_valid), 0);
    check(frag_ready == 1'b1, "R1 ready", int'(frag_ready), 1);

    upload(DEPTH, '0, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      logic [79:0] v;
      v = VEC[i];
      set_size(v[13:12]);
      lookup(v[79:48], v[47:16], v[15], v[14]);
      check(texel_valid == 1'b1, "R10 valid", int'(texel_valid), 1);
      check(texel_data == pat(int'(v[11:0])), "R2-R7 vector", int'(texel_data),
            int'(pat(int'(v[11:0]))));
    end
    set_size(2'd0);

    // R9: fragment waits during an upload window
    @(negedge clk);
    load_active = 1'b1;
    frag_s = 32'h2000_0000; frag_t = 32'h1000_0000;
    frag_clamp_s = 1'b0; frag_clamp_t = 1'b0; frag_valid = 1'b1;
    @(negedge clk);
    check(frag_ready == 1'b0, "R9 ready", int'(frag_ready), 0);
    check(load_ready == 1'b1, "R8 load_ready", int'(load_ready), 1);
    @(negedge clk);
    check(texel_valid == 1'b0, "R9 no accept", int'(texel_valid), 0);
    load_active = 1'b0;
    @(negedge clk);
    frag_valid = 1'b0;
    check(texel_valid == 1'b1 && texel_data == pat(1056), "R9 after", int'(texel_data), int'(pat(1056)));

    // R10 back-pressure
    @(negedge clk);
    texel_ready = 1'b0;
    lookup(32'h3000_0000, 32'h3000_0000, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check(texel_valid == 1'b1, "R10 hold valid", int'(texel_valid), 1);
    check(texel_data == pat(48 * 64 + 48), "R10 hold data", int'(texel_data), int'(pat(3120)));
    check(frag_ready == 1'b0, "R10 block", int'(frag_ready), 0);
    texel_ready = 1'b1;
    @(negedge clk);
    check(texel_valid == 1'b0, "R10 drain", int'(texel_valid), 0);

    // R8 partial re-upload restarts at address 0
    upload(3, 16'hBE00, 1'b0);
    lookup(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0);
    check(texel_data == 16'hBE00, "R8 addr0", int'(texel_data), 16'hBE00);
    lookup(32'h0200_0000, 32'h0000_0000, 1'b0, 1'b0);
    check(texel_data == 16'hBE02, "R8 addr2", int'(texel_data), 16'hBE02);
    lookup(32'h0300_0000, 32'h0000_0000, 1'b0, 1'b0);
    check(texel_data == pat(3), "R8 addr3 kept", int'(texel_data), int'(pat(3)));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule